// File: doc/BRIEF.md
# Branch Register Target Prefetch Unit

This unit steers instruction fetch without branch opcodes. It holds eight branch registers, each with an instruction address, and each register is paired with an instruction register. The instruction register holds the word fetched from that address. Register 0 serves as the sequential program counter. Registers 1 to 7 are loaded with targets in two ways: an address-calculation write port loads a given address, and a compare port copies one of two branch registers into a destination, picking the source by a condition bit. Every such load queues a prefetch of the target word. The queue is served one request per cycle over a single-cycle instruction-memory read port.

Every instruction the pipeline issues names a 3-bit branch-register selector. Selector 0 falls through to the next sequential word, which is read over a second single-cycle port at the program counter. A nonzero selector sends control to the named register's target and supplies the prefetched word at once. If that word has not yet arrived, the unit raises a stall until it is valid. A target written two or more instructions ahead of its use therefore transfers with no stall.

Top module: `brpf_unit`

## Requirements
- R1: After reset every branch register holds RESET_VEC (default 0x0000_0100) and no instruction register is valid: selector 0 issues RESET_VEC, any nonzero selector stalls, and no prefetch is requested.
- R2: With selector 0 the unit issues address seqAddr (the program counter) and the word seqData read there. The counter grows by 4 per issued instruction and holds while instrValid is low or stall is high.
- R3: An address-calculation write to register k (1..7) with the prefetch queue idle raises pfReq in the next cycle, with pfAddr equal to the written address.
- R4: A transfer to register k whose instruction register is valid issues with stall low, issueAddr equal to register k, and issueInstr equal to the memory word at that address. The following sequential address is that target plus 4.
- R5: A target written two or more cycles before its use, with the queue otherwise idle, transfers with no stall.
- R6: A target written in the cycle just before its use stalls for exactly one cycle and then issues.
- R7: A compare loads its destination with source T when cmpCond is 1 and source F when it is 0. It uses register values from before that cycle, and source 0 gives the current program counter.
- R8: If the compare and the address-calculation write name the same destination in one cycle, the compare's value is kept.
- R9: Two writes to distinct registers in one cycle are prefetched one per cycle, the compare's destination first.
- R10: Writes naming register 0 are ignored: the program counter is unchanged and no prefetch is requested.
- R11: Rewriting a register invalidates its instruction register, so a transfer never issues the word of the previous target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | An instruction is being issued this cycle |
| instrSel | input | 3 | Branch-register selector of that instruction (0 = fall through) |
| calcValid | input | 1 | Address-calculation write strobe |
| calcSel | input | 3 | Destination register of the address-calculation write |
| calcAddr | input | ADDR_W | Target address to write |
| cmpValid | input | 1 | Compare-assignment strobe |
| cmpCond | input | 1 | Compare outcome: 1 picks source T, 0 picks source F |
| cmpDst | input | 3 | Destination register of the compare |
| cmpSrcT | input | 3 | Source register used when the condition is true |
| cmpSrcF | input | 3 | Source register used when the condition is false |
| stall | output | 1 | Selected target word not yet valid; hold the instruction |
| issueAddr | output | ADDR_W | Address of the instruction issued under the selector |
| issueInstr | output | INSTR_W | Instruction word issued under the selector |
| seqAddr | output | ADDR_W | Sequential fetch address (program counter) |
| seqData | input | INSTR_W | Memory word at seqAddr, same cycle |
| pfReq | output | 1 | Prefetch read request |
| pfAddr | output | ADDR_W | Prefetch read address |
| pfData | input | INSTR_W | Memory word at pfAddr, same cycle |

## Verification
The issue outputs and stall are combinational on the selector, so they are sampled one time step after the inputs change, in the same cycle. A register write shows up as a prefetch request in the next cycle and as a valid instruction one cycle after that. So a transfer is checked two cycles after the write for the no-stall case, and one cycle after it for the single-stall case. The bench models every branch register and the program counter arithmetically. It predicts pfReq and pfAddr for each cycle of the queue drain and samples at those exact offsets, never waiting loosely for an event.

// File: rtl/brpf_pkg.sv
package brpf_pkg;
  localparam int IDX_W  = 3;
  localparam int NUM_BR = 1 << IDX_W;

  typedef struct packed {
    logic             wrCalc;
    logic             wrCmp;
    logic             fill;
    logic [IDX_W-1:0] fillIdx;
    logic             take;
    logic             seqAdv;
  } strobe_t;
endpackage

// File: rtl/brpf_ctrl.sv
module brpf_ctrl
  import brpf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [IDX_W-1:0] instrSel,
  input  logic             calcValid,
  input  logic [IDX_W-1:0] calcSel,
  input  logic             cmpValid,
  input  logic [IDX_W-1:0] cmpDst,
  output logic             stall,
  output logic             pfReq,
  output strobe_t          st
);
  localparam int PTR_W = IDX_W + 1;

  logic [IDX_W-1:0]  queue [NUM_BR];
  logic [PTR_W-1:0]  rdPtr, wrPtr, wrPtr2;
  logic [NUM_BR-1:0] pending, pendingNext, irValid, irValidNext, wrMask;
  logic              calcHit, cmpHit, calcEff, serve, pushCmp, pushCalc;
  logic [IDX_W-1:0]  head;

  assign calcHit = calcValid && (calcSel != '0);
  assign cmpHit  = cmpValid && (cmpDst != '0);
  assign calcEff = calcHit && !(cmpHit && (cmpDst == calcSel));
  assign serve   = (rdPtr != wrPtr);
  assign head    = queue[rdPtr[IDX_W-1:0]];

  always_comb begin
    wrMask = '0;
    if (cmpHit)  wrMask[cmpDst]  = 1'b1;
    if (calcEff) wrMask[calcSel] = 1'b1;
  end

  // queue each register at most once; a register served this cycle may requeue
  assign pushCmp  = cmpHit  && (!pending[cmpDst]  || (serve && head == cmpDst));
  assign pushCalc = calcEff && (!pending[calcSel] || (serve && head == calcSel));
  assign wrPtr2   = wrPtr + PTR_W'(pushCmp);

  always_comb begin
    pendingNext = pending;
    irValidNext = irValid;
    if (serve) begin
      pendingNext[head] = 1'b0;
      irValidNext[head] = 1'b1;
    end
    for (int i = 0; i < NUM_BR; i++) begin
      if (wrMask[i]) begin
        pendingNext[i] = 1'b1;
        irValidNext[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pushCmp)  queue[wrPtr[IDX_W-1:0]]  <= cmpDst;
    if (pushCalc) queue[wrPtr2[IDX_W-1:0]] <= calcSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      pending <= '0;
      irValid <= '0;
    end else begin
      rdPtr   <= rdPtr + PTR_W'(serve);
      wrPtr   <= wrPtr2 + PTR_W'(pushCalc);
      pending <= pendingNext;
      irValid <= irValidNext;
    end
  end

  assign stall = instrValid && (instrSel != '0) && !irValid[instrSel];
  assign pfReq = serve;

  assign st.wrCalc  = calcEff;
  assign st.wrCmp   = cmpHit;
  assign st.fill    = serve;
  assign st.fillIdx = head;
  assign st.take    = instrValid && !stall && (instrSel != '0);
  assign st.seqAdv  = instrValid && !stall && (instrSel == '0);
endmodule

// File: rtl/brpf_dpath.sv
module brpf_dpath
  import brpf_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          INSTR_W   = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [IDX_W-1:0]   instrSel,
  input  logic [IDX_W-1:0]   calcSel,
  input  logic [ADDR_W-1:0]  calcAddr,
  input  logic               cmpCond,
  input  logic [IDX_W-1:0]   cmpDst,
  input  logic [IDX_W-1:0]   cmpSrcT,
  input  logic [IDX_W-1:0]   cmpSrcF,
  input  logic [INSTR_W-1:0] seqData,
  input  logic [INSTR_W-1:0] pfData,
  output logic [ADDR_W-1:0]  issueAddr,
  output logic [INSTR_W-1:0] issueInstr,
  output logic [ADDR_W-1:0]  seqAddr,
  output logic [ADDR_W-1:0]  pfAddr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0]  br [NUM_BR];
  logic [INSTR_W-1:0] ir [NUM_BR];
  logic [ADDR_W-1:0]  cmpVal;

  assign cmpVal = cmpCond ? br[cmpSrcT] : br[cmpSrcF];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BR; i++) br[i] <= ADDR_W'(RESET_VEC);
    end else begin
      if (st.wrCalc) br[calcSel] <= calcAddr;
      if (st.wrCmp)  br[cmpDst]  <= cmpVal;
      if (st.take)        br[0] <= br[instrSel] + STEP;
      else if (st.seqAdv) br[0] <= br[0] + STEP;
    end
  end

  for (genvar g = 0; g < NUM_BR; g++) begin : g_ir
    always_ff @(posedge clk) begin
      if (!rstN)                          ir[g] <= '0;
      else if (st.fill && st.fillIdx == g) ir[g] <= pfData;
    end
  end

  assign seqAddr    = br[0];
  assign pfAddr     = br[st.fillIdx];
  assign issueAddr  = br[instrSel];
  assign issueInstr = (instrSel == '0) ? seqData : ir[instrSel];
endmodule

// File: rtl/brpf_unit.sv
module brpf_unit
  import brpf_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          INSTR_W   = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [2:0]         instrSel,
  input  logic               calcValid,
  input  logic [2:0]         calcSel,
  input  logic [ADDR_W-1:0]  calcAddr,
  input  logic               cmpValid,
  input  logic               cmpCond,
  input  logic [2:0]         cmpDst,
  input  logic [2:0]         cmpSrcT,
  input  logic [2:0]         cmpSrcF,
  output logic               stall,
  output logic [ADDR_W-1:0]  issueAddr,
  output logic [INSTR_W-1:0] issueInstr,
  output logic [ADDR_W-1:0]  seqAddr,
  input  logic [INSTR_W-1:0] seqData,
  output logic               pfReq,
  output logic [ADDR_W-1:0]  pfAddr,
  input  logic [INSTR_W-1:0] pfData
);
  strobe_t st;

  brpf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrSel(instrSel),
    .calcValid(calcValid), .calcSel(calcSel), .cmpValid(cmpValid), .cmpDst(cmpDst),
    .stall(stall), .pfReq(pfReq), .st(st)
  );

  brpf_dpath #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .RESET_VEC(RESET_VEC)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .instrSel(instrSel), .calcSel(calcSel),
    .calcAddr(calcAddr), .cmpCond(cmpCond), .cmpDst(cmpDst), .cmpSrcT(cmpSrcT),
    .cmpSrcF(cmpSrcF), .seqData(seqData), .pfData(pfData), .issueAddr(issueAddr),
    .issueInstr(issueInstr), .seqAddr(seqAddr), .pfAddr(pfAddr)
  );
endmodule

// File: rtl/brpf_unit_chk.sv
module brpf_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [2:0]        instrSel,
  input logic              calcValid,
  input logic [2:0]        calcSel,
  input logic [ADDR_W-1:0] calcAddr,
  input logic              cmpValid,
  input logic              stall,
  input logic [ADDR_W-1:0] issueAddr,
  input logic [ADDR_W-1:0] seqAddr,
  input logic              pfReq,
  input logic [ADDR_W-1:0] pfAddr
);
  // R6
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (instrValid && instrSel != 3'd0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !stall && instrSel == 3'd0) |=> seqAddr == $past(seqAddr) + ADDR_W'(4));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(seqAddr));

  // R4
  take_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !stall && instrSel != 3'd0) |=> seqAddr == $past(issueAddr) + ADDR_W'(4));

  // R3
  write_prefetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calcValid && calcSel != 3'd0 && !cmpValid && !pfReq) |=> (pfReq && pfAddr == $past(calcAddr)));

  // R10
  zero_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calcValid && calcSel == 3'd0 && !cmpValid && !pfReq) |=> !pfReq);
endmodule

bind brpf_unit brpf_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrSel(instrSel),
  .calcValid(calcValid), .calcSel(calcSel), .calcAddr(calcAddr), .cmpValid(cmpValid),
  .stall(stall), .issueAddr(issueAddr), .seqAddr(seqAddr), .pfReq(pfReq), .pfAddr(pfAddr)
);

// File: tb/brpf_unit_bench.sv
`timescale 1ns/1ps
module brpf_unit_bench;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrValid, calcValid, cmpValid, cmpCond;
  logic [2:0]  instrSel, calcSel, cmpDst, cmpSrcT, cmpSrcF;
  logic [31:0] calcAddr;
  logic        stall, pfReq;
  logic [31:0] issueAddr, issueInstr, seqAddr, seqData, pfAddr, pfData;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] expBr [8];
  logic [31:0] expPc;

  always #2 clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return (a * 32'd3) ^ 32'h5A5A_0000;
  endfunction

  assign seqData = memFn(seqAddr);
  assign pfData  = memFn(pfAddr);

  brpf_unit u_brpf_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrSel(instrSel),
    .calcValid(calcValid), .calcSel(calcSel), .calcAddr(calcAddr), .cmpValid(cmpValid),
    .cmpCond(cmpCond), .cmpDst(cmpDst), .cmpSrcT(cmpSrcT), .cmpSrcF(cmpSrcF),
    .stall(stall), .issueAddr(issueAddr), .issueInstr(issueInstr), .seqAddr(seqAddr),
    .seqData(seqData), .pfReq(pfReq), .pfAddr(pfAddr), .pfData(pfData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    instrValid = 0; instrSel = 0; calcValid = 0; calcSel = 0; calcAddr = 0;
    cmpValid = 0; cmpCond = 0; cmpDst = 0; cmpSrcT = 0; cmpSrcF = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic issueSeq(input string req);
    instrValid = 1; instrSel = 0; #1;
    chk(req, issueAddr, expPc);
    chk(req, issueInstr, memFn(expPc));
    step();
    expPc += 4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] val, x;
    rstN = 0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int i = 0; i < 8; i++) expBr[i] = RV;
    expPc = RV;

    // R1: reset state
    #1;
    chk("R1", {31'd0, pfReq}, 32'd0);
    for (int k = 1; k < 8; k++) begin
      instrValid = 1; instrSel = 3'(k); #1;
      chk("R1", {31'd0, stall}, 32'd1);
    end
    instrSel = 0; #1;
    chk("R1", issueAddr, RV);
    step();
    expPc += 4;

    // R2: sequential flow, and hold while no instruction is issued
    for (int i = 0; i < 4; i++) issueSeq("R2");
    step();
    issueSeq("R2");

    // R3 R4 R5: sweep all target registers, used two cycles after the write
    for (int k = 1; k < 8; k++) begin
      x = 32'h1000_0000 + 32'(k) * 32'h0000_0140;
      calcValid = 1; calcSel = 3'(k); calcAddr = x;
      step();
      #1;
      chk("R3", {31'd0, pfReq}, 32'd1);
      chk("R3", pfAddr, x);
      step();
      instrValid = 1; instrSel = 3'(k); #1;
      chk("R5", {31'd0, stall}, 32'd0);
      chk("R4", issueAddr, x);
      chk("R4", issueInstr, memFn(x));
      step();
      expBr[k] = x;
      expPc = x + 4;
      issueSeq("R4");
    end

    // R6: use in the cycle right after the write stalls once
    x = 32'h2000_0A00;
    calcValid = 1; calcSel = 3'd5; calcAddr = x;
    step();
    instrValid = 1; instrSel = 3'd5; #1;
    chk("R6", {31'd0, stall}, 32'd1);
    step();
    instrValid = 1; instrSel = 3'd5; #1;
    chk("R6", {31'd0, stall}, 32'd0);
    chk("R6", issueAddr, x);
    step();
    expBr[5] = x;
    expPc = x + 4;
    issueSeq("R6");

    // R7: compare assignment, both outcomes, source 0 = program counter
    for (int c = 0; c < 4; c++) begin
      logic cnd;
      logic [2:0] d, t, f;
      case (c)
        0: begin cnd = 1; d = 2; t = 3; f = 4; end
        1: begin cnd = 0; d = 6; t = 1; f = 7; end
        2: begin cnd = 1; d = 4; t = 0; f = 5; end
        default: begin cnd = 0; d = 1; t = 2; f = 2; end
      endcase
      expBr[0] = expPc;
      val = cnd ? expBr[t] : expBr[f];
      cmpValid = 1; cmpCond = cnd; cmpDst = d; cmpSrcT = t; cmpSrcF = f;
      step();
      #1;
      chk("R7", pfAddr, val);
      step();
      instrValid = 1; instrSel = d; #1;
      chk("R7", {31'd0, stall}, 32'd0);
      chk("R7", issueAddr, val);
      chk("R7", issueInstr, memFn(val));
      step();
      expBr[d] = val;
      expPc = val + 4;
    end

    // R8: same destination in one cycle, compare wins
    val = expBr[1];
    calcValid = 1; calcSel = 3'd3; calcAddr = 32'hDEAD_0000;
    cmpValid = 1; cmpCond = 1; cmpDst = 3'd3; cmpSrcT = 3'd1; cmpSrcF = 3'd1;
    step();
    step();
    instrValid = 1; instrSel = 3'd3; #1;
    chk("R8", issueAddr, val);
    step();
    expBr[3] = val;
    expPc = val + 4;

    // R9: two destinations in one cycle, compare's prefetch first
    val = expBr[1];
    x = 32'h3000_0040;
    calcValid = 1; calcSel = 3'd6; calcAddr = x;
    cmpValid = 1; cmpCond = 0; cmpDst = 3'd2; cmpSrcT = 3'd5; cmpSrcF = 3'd1;
    step();
    #1;
    chk("R9", {31'd0, pfReq}, 32'd1);
    chk("R9", pfAddr, val);
    step();
    #1;
    chk("R9", {31'd0, pfReq}, 32'd1);
    chk("R9", pfAddr, x);
    step();
    #1;
    chk("R9", {31'd0, pfReq}, 32'd0);
    instrValid = 1; instrSel = 3'd6; #1;
    chk("R9", {31'd0, stall}, 32'd0);
    chk("R9", issueAddr, x);
    step();
    expBr[6] = x;
    expBr[2] = val;
    expPc = x + 4;

    // R10: writes naming register 0 are dropped
    calcValid = 1; calcSel = 3'd0; calcAddr = 32'h7777_0000;
    cmpValid = 1; cmpCond = 1; cmpDst = 3'd0; cmpSrcT = 3'd3; cmpSrcF = 3'd3;
    step();
    #1;
    chk("R10", {31'd0, pfReq}, 32'd0);
    issueSeq("R10");

    // R11: rewrite invalidates the old word
    x = 32'h4400_0100;
    calcValid = 1; calcSel = 3'd7; calcAddr = x;
    step();
    instrValid = 1; instrSel = 3'd7; #1;
    chk("R11", {31'd0, stall}, 32'd1);
    step();
    instrValid = 1; instrSel = 3'd7; #1;
    chk("R11", {31'd0, stall}, 32'd0);
    chk("R11", issueInstr, memFn(x));
    step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule